// File: doc/BRIEF.md
# Two-Stage Bark/Bite Watchdog

This block is a watchdog timer that fires in two steps. Once software arms it, a first counter counts one-second ticks up to a programmed limit and then raises an early-warning "bark": a status bit plus a level interrupt. A second counter then starts and, if software still has not serviced the watchdog, ends in a "bite". The bite is a one-cycle reset request that carries a 3-bit code naming the kind of reset wanted.

Software services the watchdog by writing a kick bit, which restarts the count from the start of the first stage. It reads and writes the block through a byte-wide register port. The first-stage limit holds the total timeout minus the warning lead time, and the second-stage limit holds that lead time. The block also keeps a sticky flag that records that the last reset request came from the watchdog, so software can read it after the system restarts.

Top module: `wdg_bark_bite`

## Requirements
- R1: After reset, the stage-1 limit (offset 0x54) reads 32, the stage-2 limit (0x55) reads 0, the reset-type register (0x56) reads 7, the arm register (0x57) reads 0, the status register (0x10) reads 0, and bark_irq and rst_req are low.
- R2: The limit registers keep 7 bits and read bit 7 as 0. The reset-type register keeps 3 bits. The arm register keeps only bit 7. Unmapped offsets read 0.
- R3: While the arm bit (0x57 bit 7) is 0, ticks have no effect: bark_irq stays low and no rst_req is issued.
- R4: After arming, bark_irq and status bit 6 (0x10) go high on the tick numbered S1, counted from the arming write, where S1 is the stage-1 limit. A limit of 0 acts as 1.
- R5: The bite comes on the S2-th tick after the bark, where a stage-2 limit of 0 acts as 1 (the next tick). rst_req is high for exactly one cycle, and rst_type carries the reset-type register value as it stands when the bite happens. Codes 1, 4 and 7 mean warm reset, shutdown and hard reset.
- R6: Writing a byte with bit 0 set to offset 0x58 while armed clears the bark and restarts stage 1 from zero. A write with bit 0 clear, or any write there while disarmed, has no effect.
- R7: Writing 0x57 with bit 7 clear disarms the block, clears the bark at once, and prevents any later rst_req.
- R8: After a bite the counters stop. The bark stays high and no further rst_req comes until a kick, or a write of 0x57 with bit 7 set, restarts stage 1.
- R9: A bite sets bit 2 of offset 0x0C. The bit stays set until a write with bit 2 set to 0x0C clears it. Writes with bit 2 clear leave it set.
- R10: When a register write and a tick fall in the same cycle, the write takes effect and that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| tick_1s | input | 1 | One-cycle pulse per second |
| bark_irq | output | 1 | Level interrupt, high while the bark status is set |
| rst_req | output | 1 | One-cycle reset request at bite |
| rst_type | output | 3 | Reset type code latched at bite |

## Verification
The assertions assume that tick_1s and bus_en are single-cycle strobes that are never left high, and that no register access happens while rst_n is low. The bench drives every strobe for exactly one clock, starting and ending on falling edges, and drives reset only before the first access. The random part draws stage limits from 0 to 6 and reset codes from the three defined values. This keeps each scenario short, while the directed cases cover a kick on the same cycle as a tick, a limit of 0, and a reset-type change between bark and bite.

// File: rtl/wdg_pkg.sv
// Package: shared offsets, bit positions and types for the bark/bite watchdog.
// Assumes an 8-bit register port; offsets are fixed because software decodes them.
package wdg_pkg;
    typedef enum logic [1:0] {
        WD_IDLE   = 2'd0,
        WD_STG1   = 2'd1,
        WD_STG2   = 2'd2,
        WD_BITTEN = 2'd3
    } wd_state_e;

    localparam logic [7:0] OFS_POFF = 8'h0C;
    localparam logic [7:0] OFS_STAT = 8'h10;
    localparam logic [7:0] OFS_LIM1 = 8'h54;
    localparam logic [7:0] OFS_LIM2 = 8'h55;
    localparam logic [7:0] OFS_ACT  = 8'h56;
    localparam logic [7:0] OFS_ARM  = 8'h57;
    localparam logic [7:0] OFS_KICK = 8'h58;

    localparam int POFF_WDOG_BIT = 2;
    localparam int STAT_BARK_BIT = 6;
    localparam int ARM_BIT       = 7;
    localparam int KICK_BIT      = 0;

    // One-cycle commands decoded from register writes
    typedef struct packed {
        logic kick;
        logic arm;
        logic disarm;
    } wd_cmd_t;
endpackage

// File: rtl/wdg_regs.sv
// Module: register file and write decoder for the watchdog.
// Holds the limits, the reset type, the arm bit and the sticky power-off flag,
// turns writes into one-cycle commands for the timer, and muxes read data.
// Assumes bus_en is a single-cycle strobe per access.
module wdg_regs
    import wdg_pkg::*;
#(
    parameter int DW       = 8,
    parameter int TW       = 7,
    parameter int TYPEW    = 3,
    parameter int LIM1_RST = 32,
    parameter int LIM2_RST = 0,
    parameter int ACT_RST  = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_en,
    input  logic             bus_we,
    input  logic [7:0]       bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic             bark,
    input  logic             bite,
    output logic [TW-1:0]    lim1,
    output logic [TW-1:0]    lim2,
    output logic [TYPEW-1:0] act,
    output logic             arm_q,
    output wd_cmd_t          cmd
);
    logic wr;
    logic poff_q;

    assign wr = bus_en && bus_we;

    // Decode write strobes into timer commands
    always_comb begin
        cmd.kick   = wr && (bus_addr == OFS_KICK) && bus_wdata[KICK_BIT];
        cmd.arm    = wr && (bus_addr == OFS_ARM)  && bus_wdata[ARM_BIT];
        cmd.disarm = wr && (bus_addr == OFS_ARM)  && !bus_wdata[ARM_BIT];
    end

    // Configuration registers: limits, reset type and arm bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim1  <= TW'(LIM1_RST);
            lim2  <= TW'(LIM2_RST);
            act   <= TYPEW'(ACT_RST);
            arm_q <= 1'b0;
        end else if (wr) begin
            case (bus_addr)
                OFS_LIM1: lim1  <= bus_wdata[TW-1:0];
                OFS_LIM2: lim2  <= bus_wdata[TW-1:0];
                OFS_ACT:  act   <= bus_wdata[TYPEW-1:0];
                OFS_ARM:  arm_q <= bus_wdata[ARM_BIT];
                default:  ;
            endcase
        end
    end

    // Sticky watchdog power-off flag: set by bite, cleared by write-one
    always_ff @(posedge clk) begin
        if (!rst_n)
            poff_q <= 1'b0;
        else if (bite)
            poff_q <= 1'b1;
        else if (wr && (bus_addr == OFS_POFF) && bus_wdata[POFF_WDOG_BIT])
            poff_q <= 1'b0;
    end

    // Read data mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_LIM1: bus_rdata = DW'(lim1);
            OFS_LIM2: bus_rdata = DW'(lim2);
            OFS_ACT:  bus_rdata = DW'(act);
            OFS_ARM:  bus_rdata[ARM_BIT] = arm_q;
            OFS_STAT: bus_rdata[STAT_BARK_BIT] = bark;
            OFS_POFF: bus_rdata[POFF_WDOG_BIT] = poff_q;
            default:  bus_rdata = '0;
        endcase
    end

    // R9: a bite always leaves the flag set on the next cycle
    assert_poff_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bite |=> poff_q);

    // R9: the flag only drops after a write-one to its offset
    assert_poff_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (poff_q && !(wr && bus_addr == OFS_POFF)) |=> poff_q);

    // R7: a disarmed block never holds a bark
    assert_disarm_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_q |-> !bark);
endmodule

// File: rtl/wdg_stage_timer.sv
// Module: two-stage tick counter and sequencer for the watchdog.
// Counts tick pulses through stage 1 (to bark) and stage 2 (to bite),
// emits a one-cycle bite pulse with the latched reset type, then stops.
// Commands win over a tick in the same cycle. Assumes tick is one cycle wide.
module wdg_stage_timer
    import wdg_pkg::*;
#(
    parameter int TW    = 7,
    parameter int TYPEW = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  wd_cmd_t          cmd,
    input  logic [TW-1:0]    lim1,
    input  logic [TW-1:0]    lim2,
    input  logic [TYPEW-1:0] act,
    output logic             bark,
    output logic             bite,
    output logic [TYPEW-1:0] bite_type
);
    wd_state_e   state;
    logic [TW-1:0] cnt;
    logic [TW:0]   cnt_inc;
    logic [TW:0]   lim1_eff;
    logic [TW:0]   lim2_eff;
    logic          restart;

    // Effective limits: zero acts as one tick
    always_comb begin
        cnt_inc  = {1'b0, cnt} + 1'b1;
        lim1_eff = (lim1 == '0) ? (TW+1)'(1) : {1'b0, lim1};
        lim2_eff = (lim2 == '0) ? (TW+1)'(1) : {1'b0, lim2};
        restart  = (cmd.arm && (state == WD_IDLE || state == WD_BITTEN)) ||
                   (cmd.kick && state != WD_IDLE);
    end

    // Stage sequencer with command priority over ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= WD_IDLE;
            cnt       <= '0;
            bark      <= 1'b0;
            bite      <= 1'b0;
            bite_type <= '0;
        end else begin
            bite <= 1'b0;
            if (cmd.disarm) begin
                state <= WD_IDLE;
                cnt   <= '0;
                bark  <= 1'b0;
            end else if (restart) begin
                state <= WD_STG1;
                cnt   <= '0;
                bark  <= 1'b0;
            end else if (tick) begin
                case (state)
                    WD_STG1: begin
                        if (cnt_inc >= lim1_eff) begin
                            state <= WD_STG2;
                            cnt   <= '0;
                            bark  <= 1'b1;
                        end else begin
                            cnt <= cnt_inc[TW-1:0];
                        end
                    end
                    WD_STG2: begin
                        if (cnt_inc >= lim2_eff) begin
                            state     <= WD_BITTEN;
                            cnt       <= '0;
                            bite      <= 1'b1;
                            bite_type <= act;
                        end else begin
                            cnt <= cnt_inc[TW-1:0];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R5: the reset request is a single-cycle pulse
    assert_bite_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bite |=> !bite);

    // R5: a bite is always preceded by a bark that is still standing
    assert_bite_after_bark_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bite |-> bark);

    // R3: an idle timer neither barks nor bites
    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_IDLE) |-> (!bark && !bite));

    // R6: the bark only clears after a register command
    assert_bark_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bark) |-> $past(cmd.kick || cmd.arm || cmd.disarm));

    // R8: once bitten, the timer holds until a command arrives
    assert_bitten_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_BITTEN && !(cmd.kick || cmd.arm || cmd.disarm))
            |=> (state == WD_BITTEN && !bite));
endmodule

// File: rtl/wdg_bark_bite.sv
// Module: top of the two-stage bark/bite watchdog.
// Connects the register file to the stage timer; bark drives the level
// interrupt and the bite pulse drives the reset request with its type code.
// Assumes tick_1s is a one-cycle strobe generated outside the block.
module wdg_bark_bite
    import wdg_pkg::*;
#(
    parameter int TW       = 7,
    parameter int TYPEW    = 3,
    parameter int LIM1_RST = 32,
    parameter int LIM2_RST = 0,
    parameter int ACT_RST  = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_en,
    input  logic             bus_we,
    input  logic [7:0]       bus_addr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic             tick_1s,
    output logic             bark_irq,
    output logic             rst_req,
    output logic [TYPEW-1:0] rst_type
);
    localparam int DW = 8;

    logic [TW-1:0]    lim1;
    logic [TW-1:0]    lim2;
    logic [TYPEW-1:0] act;
    logic             arm_q;
    logic             bark;
    logic             bite;
    wd_cmd_t          cmd;

    wdg_regs #(
        .DW(DW), .TW(TW), .TYPEW(TYPEW),
        .LIM1_RST(LIM1_RST), .LIM2_RST(LIM2_RST), .ACT_RST(ACT_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bark(bark), .bite(bite),
        .lim1(lim1), .lim2(lim2), .act(act), .arm_q(arm_q), .cmd(cmd)
    );

    wdg_stage_timer #(.TW(TW), .TYPEW(TYPEW)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick_1s), .cmd(cmd),
        .lim1(lim1), .lim2(lim2), .act(act),
        .bark(bark), .bite(bite), .bite_type(rst_type)
    );

    assign bark_irq = bark;
    assign rst_req  = bite;

    // R7: the reset request never fires while disarmed
    assert_no_req_disarmed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> arm_q);
endmodule

// File: tb/wdg_bark_bite_bench.sv
// Bench: directed corner cases plus seeded random stage/type scenarios.
module wdg_bark_bite_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_en = 1'b0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       tick_1s = 1'b0;
    logic       bark_irq;
    logic       rst_req;
    logic [2:0] rst_type;

    int n_chk = 0;
    int n_fail = 0;
    int req_cnt = 0;
    logic [2:0] req_last = '0;

    always #2 clk = ~clk;

    wdg_bark_bite u_wdg_bark_bite (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_1s(tick_1s), .bark_irq(bark_irq), .rst_req(rst_req), .rst_type(rst_type)
    );

    // Count reset-request pulses away from the active edge
    always @(negedge clk) begin
        if (rst_req) begin
            req_cnt  = req_cnt + 1;
            req_last = rst_type;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic tick();
        @(negedge clk);
        tick_1s = 1'b1;
        @(negedge clk);
        tick_1s = 1'b0;
        #1;
    endtask

    task automatic tick_and_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        tick_1s = 1'b1; bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        tick_1s = 1'b0; bus_en = 1'b0; bus_we = 1'b0;
        #1;
    endtask

    function automatic int eff(input int lim);
        return (lim == 0) ? 1 : lim;
    endfunction

    // Expected: bark is up after tick i once i reaches the stage-1 limit
    function automatic logic exp_bark(input int i, input int s1);
        return (i >= eff(s1)) ? 1'b1 : 1'b0;
    endfunction

    // Expected number of bites after tick i (counters stop after one)
    function automatic int exp_bites(input int i, input int s1, input int s2);
        return (i >= eff(s1) + eff(s2)) ? 1 : 0;
    endfunction

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int base;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R1 reset state
        rd(8'h54, d); chk("R1 lim1", d, 32);
        rd(8'h55, d); chk("R1 lim2", d, 0);
        rd(8'h56, d); chk("R1 type", d, 7);
        rd(8'h57, d); chk("R1 arm", d, 0);
        rd(8'h10, d); chk("R1 status", d, 0);
        chk("R1 irq", bark_irq, 0);
        chk("R1 req", rst_req, 0);

        // R2 field widths
        wr(8'h54, 8'hFF); rd(8'h54, d); chk("R2 lim1 width", d, 8'h7F);
        wr(8'h55, 8'hAA); rd(8'h55, d); chk("R2 lim2 width", d, 8'h2A);
        wr(8'h56, 8'hFF); rd(8'h56, d); chk("R2 type width", d, 8'h07);
        wr(8'h57, 8'hFF); rd(8'h57, d); chk("R2 arm width", d, 8'h80);
        wr(8'h57, 8'h00);
        rd(8'h33, d); chk("R2 unmapped", d, 0);

        // R3 disarmed ticks do nothing
        wr(8'h54, 8'd1); wr(8'h55, 8'd0);
        base = req_cnt;
        repeat (5) tick();
        chk("R3 irq", bark_irq, 0);
        chk("R3 req", req_cnt - base, 0);

        // R4 limit 0 acts as 1; R5 zero stage-2 bites on next tick
        wr(8'h54, 8'd0); wr(8'h56, 8'd4); wr(8'h57, 8'h80);
        base = req_cnt;
        tick(); chk("R4 zero lim bark", bark_irq, 1);
        rd(8'h10, d); chk("R4 status bit6", d, 8'h40);
        chk("R5 no early bite", req_cnt - base, 0);
        tick(); chk("R5 zero lim2 bite", req_cnt - base, 1);
        chk("R5 type", req_last, 4);
        // R8 counters stopped after bite, bark held
        repeat (4) tick();
        chk("R8 no second bite", req_cnt - base, 1);
        chk("R8 bark held", bark_irq, 1);
        // R9 sticky flag
        rd(8'h0C, d); chk("R9 flag set", d, 8'h04);
        wr(8'h0C, 8'hFB); rd(8'h0C, d); chk("R9 write0 keeps", d, 8'h04);
        wr(8'h0C, 8'h04); rd(8'h0C, d); chk("R9 w1c clears", d, 8'h00);
        // R8 re-arm restarts from bitten
        wr(8'h57, 8'h80);
        chk("R8 rearm clears bark", bark_irq, 0);
        tick(); tick();
        chk("R8 rearm bites again", req_cnt - base, 2);

        // R6 kick restarts stage 1
        wr(8'h57, 8'h00);
        wr(8'h54, 8'd5); wr(8'h55, 8'd3); wr(8'h57, 8'h80);
        base = req_cnt;
        repeat (3) tick();
        wr(8'h58, 8'h01);
        repeat (4) tick();
        chk("R6 kick restart no bark", bark_irq, 0);
        tick(); chk("R6 bark after restart", bark_irq, 1);
        wr(8'h58, 8'h00); chk("R6 bit0 clear ignored", bark_irq, 1);
        wr(8'h58, 8'h01); chk("R6 kick clears bark", bark_irq, 0);

        // R5 type sampled at bite time
        wr(8'h56, 8'd1);
        repeat (5) tick();
        wr(8'h56, 8'd7);
        tick(); tick();
        chk("R5 no bite before s2", req_cnt - base, 0);
        tick();
        chk("R5 bite count", req_cnt - base, 1);
        chk("R5 type at bite", req_last, 7);
        wr(8'h0C, 8'h04);

        // R7 disarm stops and clears
        wr(8'h57, 8'h80);
        base = req_cnt;
        repeat (5) tick();
        chk("R7 pre bark", bark_irq, 1);
        wr(8'h57, 8'h00);
        chk("R7 bark cleared", bark_irq, 0);
        repeat (10) tick();
        chk("R7 no bite", req_cnt - base, 0);
        wr(8'h58, 8'h01);
        repeat (6) tick();
        chk("R6 kick while disarmed ignored", bark_irq, 0);
        rd(8'h57, d); chk("R7 arm reads 0", d, 0);

        // R10 write beats a coincident tick
        wr(8'h54, 8'd2); wr(8'h55, 8'd4); wr(8'h57, 8'h80);
        tick();
        tick_and_wr(8'h58, 8'h01);
        chk("R10 tick dropped", bark_irq, 0);
        tick(); chk("R10 one tick after", bark_irq, 0);
        tick(); chk("R10 bark on second", bark_irq, 1);
        wr(8'h57, 8'h00);

        // Random scenarios checked against bench model (R4 R5 R8)
        for (int it = 0; it < 40; it++) begin
            int s1, s2, tsel, tot;
            logic [2:0] ty;
            s1 = $urandom_range(0, 6);
            s2 = $urandom_range(0, 6);
            tsel = $urandom_range(0, 2);
            ty = (tsel == 0) ? 3'd1 : ((tsel == 1) ? 3'd4 : 3'd7);
            wr(8'h54, 8'(s1)); wr(8'h55, 8'(s2)); wr(8'h56, {5'd0, ty});
            wr(8'h57, 8'h80);
            base = req_cnt;
            tot = eff(s1) + eff(s2) + 2;
            for (int i = 1; i <= tot; i++) begin
                tick();
                chk("R4 random bark", bark_irq, exp_bark(i, s1));
                chk("R5 random bites", req_cnt - base, exp_bites(i, s1, s2));
            end
            chk("R5 random type", req_last, ty);
            wr(8'h57, 8'h00);
            wr(8'h0C, 8'h04);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule